// File: doc/BRIEF.md
# Double-Command Converter Enable Supervisor

This block guards the enable that lets the supply converters start. The bus slave sends it one-cycle strobes. Each strobe reports a finished protocol addressed to this device: an on command, an off command, or any other protocol (setup, read-back or an unknown command). A further strobe reports that the divider registers have actually been written. The block turns the enable flag on only after a run of identical on commands. It turns the flag off only after a run of identical off commands. Any different protocol to this device in between breaks the run. Traffic to other addresses produces no strobe, so it leaves a run intact.

On commands count only after the registers have been set up at least once since reset. The registered enable flag is combined with the synchronised global enable pin level to form two outputs:
- a status bit that is active low, meaning the converters are on;
- a permit that the register block uses to refuse setup writes while the converters run.

The run length is the parameter `CONFIRM_COUNT`, which defaults to two.

Top module: `dsup_top`

## Requirements
- R1: After reset, `smbon` is 0, and both `dcon` and `setupPermit` are 1 whatever the level of `vronSync`.
- R2: Once setup is done, `smbon` becomes 1 on the clock edge that samples the second of two consecutive `onCmd` pulses. The new value is visible in the following cycle.
- R3: `smbon` becomes 0 on the clock edge that samples the second of two consecutive `offCmd` pulses.
- R4: An `otherCmd` pulse, or a command of the opposite kind, between two commands of the same kind restarts the run. Two further identical commands are then needed.
- R5: Cycles with no strobe (traffic to other addresses) do not break a run.
- R6: `onCmd` pulses are ignored until a `setupDone` pulse has been seen. This includes a pulse sampled in the same cycle as `setupDone`. An on sampled before the first setup does not count towards a later run.
- R7: `dcon` is 0 exactly when `vronSync` and `smbon` are both 1. It follows `vronSync` in the same cycle.
- R8: `setupPermit` is 0 exactly when `vronSync` and `smbon` are both 1. It returns to 1 when `vronSync` falls or when `smbon` is cleared.
- R9: The setup-done state is cleared only by reset. After turning off, two on commands turn the flag on again without a new setup.
- R10: An on command while `smbon` is 1 keeps it at 1. An off command while `smbon` is 0 keeps it at 0.
- R11: The input encoding is one-cycle active-high pulses, with at most one of `onCmd`, `offCmd` and `otherCmd` high in a cycle. `setupDone` may coincide with `otherCmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| onCmd | input | 1 | Pulse: an on protocol to this device completed |
| offCmd | input | 1 | Pulse: an off protocol to this device completed |
| otherCmd | input | 1 | Pulse: any other protocol to this device completed |
| setupDone | input | 1 | Pulse: the divider registers were written |
| vronSync | input | 1 | Synchronised global enable pin level |
| smbon | output | 1 | Registered converter enable flag |
| dcon | output | 1 | Status bit, low when the converters are on |
| setupPermit | output | 1 | High when setup writes are allowed |

## Verification
The bench targets four corner cases.

- **Single command.** A design that acted on one command would raise `smbon` a command early.
- **Broken run.** A design that kept counting across a read-back or an opposite command would turn on or off after an interrupted run. A design that reset its count on idle cycles would never finish a run that is spread out in time.
- **Before setup.** A design that counted on commands before setup, or in the same cycle as the setup strobe, would turn on one command too soon after the first setup. A design that cleared the setup state on off commands would refuse to turn on again.
- **Sweep.** Every five-symbol alphabet sequence of length four is replayed from both a fresh and a running start, with `vronSync` alternating. This exposes a wrong lock or status combination against the arithmetic model.

// File: rtl/dsup_pkg.sv
package dsup_pkg;

  typedef struct packed {
    logic onStep;
    logic onClear;
    logic goOn;
    logic offStep;
    logic offClear;
    logic goOff;
    logic markSetup;
  } supStrobe_t;

  localparam int RUN_ON  = 0;
  localparam int RUN_OFF = 1;
  localparam int RUN_KINDS = 2;

endpackage

// File: rtl/dsup_run_counter.sv
module dsup_run_counter #(
  parameter int CONFIRM_COUNT = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic step,
  input  logic clear,
  output logic atLast
);
  localparam int CNT_W = $clog2(CONFIRM_COUNT + 1);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(CONFIRM_COUNT - 1);

  logic [CNT_W-1:0] runCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCount <= '0;
    end else if (clear) begin
      runCount <= '0;
    end else if (step) begin
      runCount <= runCount + 1'b1;
    end
  end

  assign atLast = (runCount == LAST_VAL);
endmodule

// File: rtl/dsup_ctrl.sv
module dsup_ctrl
  import dsup_pkg::*;
(
  input  logic       onCmd,
  input  logic       offCmd,
  input  logic       otherCmd,
  input  logic       setupDone,
  input  logic       setupSeen,
  input  logic       onLast,
  input  logic       offLast,
  output supStrobe_t strobe
);
  logic onAccept;

  always_comb begin
    onAccept = onCmd & setupSeen;
    strobe = '0;
    strobe.goOn      = onAccept & onLast;
    strobe.onStep    = onAccept & ~onLast;
    strobe.onClear   = offCmd | otherCmd | strobe.goOn;
    strobe.goOff     = offCmd & offLast;
    strobe.offStep   = offCmd & ~offLast;
    strobe.offClear  = onCmd | otherCmd | strobe.goOff;
    strobe.markSetup = setupDone;
  end
endmodule

// File: rtl/dsup_state.sv
module dsup_state
  import dsup_pkg::*;
#(
  parameter int CONFIRM_COUNT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  supStrobe_t strobe,
  input  logic       vronSync,
  output logic       setupSeen,
  output logic       onLast,
  output logic       offLast,
  output logic       smbon,
  output logic       dcon,
  output logic       setupPermit
);
  logic [RUN_KINDS-1:0] stepVec;
  logic [RUN_KINDS-1:0] clearVec;
  logic [RUN_KINDS-1:0] lastVec;
  logic                 running;

  assign stepVec[RUN_ON]   = strobe.onStep;
  assign clearVec[RUN_ON]  = strobe.onClear;
  assign stepVec[RUN_OFF]  = strobe.offStep;
  assign clearVec[RUN_OFF] = strobe.offClear;

  for (genvar k = 0; k < RUN_KINDS; k++) begin : g_run
    dsup_run_counter #(.CONFIRM_COUNT(CONFIRM_COUNT)) i_cnt (
      .clk   (clk),
      .rstN  (rstN),
      .step  (stepVec[k]),
      .clear (clearVec[k]),
      .atLast(lastVec[k])
    );
  end

  assign onLast  = lastVec[RUN_ON];
  assign offLast = lastVec[RUN_OFF];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smbon     <= 1'b0;
      setupSeen <= 1'b0;
    end else begin
      if (strobe.markSetup) setupSeen <= 1'b1;
      if (strobe.goOn)       smbon <= 1'b1;
      else if (strobe.goOff) smbon <= 1'b0;
    end
  end

  assign running     = vronSync & smbon;
  assign dcon        = ~running;
  assign setupPermit = ~running;
endmodule

// File: rtl/dsup_top.sv
module dsup_top
  import dsup_pkg::*;
#(
  parameter int CONFIRM_COUNT = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic onCmd,
  input  logic offCmd,
  input  logic otherCmd,
  input  logic setupDone,
  input  logic vronSync,
  output logic smbon,
  output logic dcon,
  output logic setupPermit
);
  supStrobe_t strobe;
  logic       setupSeen;
  logic       onLast;
  logic       offLast;

  dsup_ctrl i_ctrl (
    .onCmd    (onCmd),
    .offCmd   (offCmd),
    .otherCmd (otherCmd),
    .setupDone(setupDone),
    .setupSeen(setupSeen),
    .onLast   (onLast),
    .offLast  (offLast),
    .strobe   (strobe)
  );

  dsup_state #(.CONFIRM_COUNT(CONFIRM_COUNT)) i_state (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .vronSync   (vronSync),
    .setupSeen  (setupSeen),
    .onLast     (onLast),
    .offLast    (offLast),
    .smbon      (smbon),
    .dcon       (dcon),
    .setupPermit(setupPermit)
  );
endmodule

// File: rtl/dsup_checker.sv
module dsup_checker (
  input logic clk,
  input logic rstN,
  input logic onCmd,
  input logic offCmd,
  input logic otherCmd,
  input logic setupDone,
  input logic vronSync,
  input logic smbon,
  input logic dcon,
  input logic setupPermit
);
  logic seenSetupChk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenSetupChk <= 1'b0;
    else if (setupDone) seenSetupChk <= 1'b1;
  end

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({onCmd, offCmd, otherCmd})); // R11

  AST_RISE_NEEDS_ON: assert property (@(posedge clk) disable iff (!rstN)
    $rose(smbon) |-> $past(onCmd)); // R2

  AST_FALL_NEEDS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $fell(smbon) |-> $past(offCmd)); // R3

  AST_RISE_NEEDS_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(smbon) |-> $past(seenSetupChk)); // R6

  AST_STATUS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    !dcon |-> !setupPermit); // R8

  AST_VRON_LOW_FREES: assert property (@(posedge clk) disable iff (!rstN)
    !vronSync |-> (dcon && setupPermit)); // R7

  AST_OFF_STAYS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!smbon && !onCmd) |=> !smbon); // R10
endmodule

bind dsup_top dsup_checker i_dsup_checker (
  .clk        (clk),
  .rstN       (rstN),
  .onCmd      (onCmd),
  .offCmd     (offCmd),
  .otherCmd   (otherCmd),
  .setupDone  (setupDone),
  .vronSync   (vronSync),
  .smbon      (smbon),
  .dcon       (dcon),
  .setupPermit(setupPermit)
);

// File: tb/test_dsup_top.sv
`timescale 1ns/1ps
module test_dsup_top;
  localparam int NEED = 2;
  localparam int SYM_IDLE = 0, SYM_ON = 1, SYM_OFF = 2, SYM_SETUP = 3, SYM_READ = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic onCmd = 1'b0, offCmd = 1'b0, otherCmd = 1'b0, setupDone = 1'b0;
  logic vronSync = 1'b1;
  logic smbon, dcon, setupPermit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic mOn, mSetup;
  int   mOnCnt, mOffCnt;

  always #4 clk = ~clk;

  dsup_top #(.CONFIRM_COUNT(NEED)) i_dsup_top (
    .clk(clk), .rstN(rstN), .onCmd(onCmd), .offCmd(offCmd),
    .otherCmd(otherCmd), .setupDone(setupDone), .vronSync(vronSync),
    .smbon(smbon), .dcon(dcon), .setupPermit(setupPermit)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chkOutputs(input string req);
    chk(req, smbon, mOn);
    chk(req, dcon, ~(vronSync & mOn));
    chk(req, setupPermit, ~(vronSync & mOn));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    mOn = 1'b0; mSetup = 1'b0; mOnCnt = 0; mOffCnt = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doStep(input int sym, input string req);
    @(negedge clk);
    case (sym)
      SYM_ON: begin
        onCmd = 1'b1;
        mOffCnt = 0;
        if (mSetup) begin
          mOnCnt++;
          if (mOnCnt == NEED) begin mOn = 1'b1; mOnCnt = 0; end
        end
      end
      SYM_OFF: begin
        offCmd = 1'b1;
        mOnCnt = 0;
        mOffCnt++;
        if (mOffCnt == NEED) begin mOn = 1'b0; mOffCnt = 0; end
      end
      SYM_SETUP: begin
        otherCmd = 1'b1; setupDone = 1'b1;
        mOnCnt = 0; mOffCnt = 0; mSetup = 1'b1;
      end
      SYM_READ: begin
        otherCmd = 1'b1;
        mOnCnt = 0; mOffCnt = 0;
      end
      default: ;
    endcase
    @(negedge clk);
    onCmd = 1'b0; offCmd = 1'b0; otherCmd = 1'b0; setupDone = 1'b0;
    chkOutputs(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state with vron high and low
    chk("R1 smbon", smbon, 1'b0);
    chk("R1 dcon", dcon, 1'b1);
    chk("R1 permit", setupPermit, 1'b1);
    vronSync = 1'b0; #1;
    chk("R1 dcon vron low", dcon, 1'b1);
    vronSync = 1'b1;

    // R6 on before setup ignored
    doStep(SYM_ON, "R6 pre-setup on");
    doStep(SYM_ON, "R6 pre-setup on");
    chk("R6 still off", smbon, 1'b0);

    // R2 and R5 run with idle gaps
    doStep(SYM_SETUP, "R6 setup");
    doStep(SYM_ON, "R2 first on");
    chk("R2 one on is not enough", smbon, 1'b0);
    doStep(SYM_IDLE, "R5 gap");
    doStep(SYM_IDLE, "R5 gap");
    doStep(SYM_ON, "R2 second on");
    chk("R2 on after two", smbon, 1'b1);
    chk("R7 dcon low", dcon, 1'b0);
    chk("R8 permit low", setupPermit, 1'b0);
    vronSync = 1'b0; #1;
    chk("R7 dcon vron low", dcon, 1'b1);
    chk("R8 permit vron low", setupPermit, 1'b1);
    vronSync = 1'b1;

    // R10 on while on
    doStep(SYM_ON, "R10 on while on");
    chk("R10 stays on", smbon, 1'b1);

    // R4 interrupted off run, then R3
    doStep(SYM_OFF, "R4 off");
    doStep(SYM_READ, "R4 read between");
    doStep(SYM_OFF, "R4 off");
    chk("R4 interrupted run", smbon, 1'b1);
    doStep(SYM_OFF, "R3 second off");
    chk("R3 off after two", smbon, 1'b0);
    chk("R8 permit back", setupPermit, 1'b1);
    doStep(SYM_OFF, "R10 off while off");
    chk("R10 stays off", smbon, 1'b0);

    // R4 opposite command breaks an on run
    doStep(SYM_ON, "R4 on");
    doStep(SYM_OFF, "R4 opposite");
    doStep(SYM_ON, "R4 on");
    chk("R4 opposite breaks run", smbon, 1'b0);

    // R9 setup state survives off
    doStep(SYM_ON, "R9 on");
    chk("R9 on again without setup", smbon, 1'b1);

    // R6 on before first setup does not count
    doReset();
    doStep(SYM_ON, "R6 early on");
    doStep(SYM_SETUP, "R6 setup");
    doStep(SYM_ON, "R6 on");
    chk("R6 early on not counted", smbon, 1'b0);
    doStep(SYM_ON, "R6 on");
    chk("R6 on after setup run", smbon, 1'b1);

    // R6 on in same cycle as setup strobe is ignored
    doReset();
    @(negedge clk);
    onCmd = 1'b1; setupDone = 1'b1;
    @(negedge clk);
    onCmd = 1'b0; setupDone = 1'b0;
    mSetup = 1'b1;
    doStep(SYM_ON, "R6 same-cycle");
    chk("R6 same-cycle on ignored", smbon, 1'b0);

    // Sweep: every length-4 sequence from two start states (R2 R3 R4 R7 R8)
    for (int start = 0; start < 2; start++) begin
      for (int seq = 0; seq < 625; seq++) begin
        doReset();
        vronSync = seq[0];
        if (start == 1) begin
          doStep(SYM_SETUP, "R2 sweep prep");
          doStep(SYM_ON, "R2 sweep prep");
          doStep(SYM_ON, "R2 sweep prep");
        end
        for (int pos = 0, rem = seq; pos < 4; pos++, rem = rem / 5) begin
          doStep(rem % 5, "R4 sweep");
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule